// File: doc/BRIEF.md
# Downlink Gold Scrambling Code Generator

The block produces the complex scrambling chip stream that multiplies the spread downlink signal. A code number n between 0 and 8191 is applied together with a one-cycle load strobe. The block then places its two 18-stage shift registers in their fixed starting states. It advances the first register n steps, one step per clock, and holds a busy flag high while it does so.

After that, each cycle with the chip enable high yields one complex chip with I and Q values of +1 or -1. The chip stream is the modulo-2 sum of two maximal-length sequences, which is a Gold sequence. The Q part is the same sum taken 131072 positions further along. After 38400 chips the sequence starts again from its first chip, which gives one full radio frame per cycle of the stream. A frame marker accompanies the first chip of every frame.

The block also reports how the code number fits into the code plan:
- whether it is a primary code (a multiple of 16);
- its set index, the integer part of n/16;
- its primary group number, the integer part of n/128, which gives 64 groups of eight primary codes.

Top module: `scramble_gold_gen`

## Requirements
- R1: After reset, busy, chip_valid and frame_start are all low.
- R2: One cycle after load, is_primary is high exactly when the low four bits of the code are zero, set_index equals code/16 and group_num equals code/128. All three hold until the next load.
- R3: After a load of code n, busy is high for exactly n consecutive cycles, starting the cycle after load. A load of code 0 never raises busy.
- R4: chip_en has no effect, and chip_valid stays low, while busy is high or before the first load after reset.
- R5: A chip value is 2'b01 for +1 and 2'b11 for -1; a binary 0 maps to +1. The I chip is x[0] xor y[0]. The registers x and y step as {fb, s[17:1]}, where x's feedback is x[0]^x[7] and y's feedback is y[0]^y[5]^y[7]^y[10]. At load, x = 1 and y = all ones, and x is then stepped n times.
- R6: The Q chip equals the I sum of the same code taken 131072 positions later. For x, position 131072 is x stepped n+131072 times from its start state; for y, it is y stepped 131072 times.
- R7: frame_start is high together with the first chip after the advance and with every 38400th chip after it. The chip after the 38400th is the same as the first chip.
- R8: A load while chips are being produced abandons the current sequence and restarts from the new code.
- R9: chip_valid goes high one cycle after each cycle in which chip_en is high and the block is ready. A gap in chip_en pauses the stream without losing a chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | One-cycle strobe that takes code_num and restarts |
| code_num | input | 13 | Scrambling code number 0..8191 |
| chip_en | input | 1 | Request for one chip |
| busy | output | 1 | High while the x register is being advanced |
| chip_valid | output | 1 | A chip is present on chip_i/chip_q |
| frame_start | output | 1 | The chip present is chip 0 of a frame |
| chip_i | output | 2 | I chip, 2'b01 = +1, 2'b11 = -1 |
| chip_q | output | 2 | Q chip, same encoding |
| is_primary | output | 1 | Loaded code is a primary code |
| set_index | output | 9 | Loaded code divided by 16 |
| group_num | output | 6 | Loaded code divided by 128 |

## Verification
The assertions assume that load is a single-cycle strobe and that code_num is meaningful only in that cycle. They also assume that chip_en may arrive in any cycle, including while busy. The bench drives load for exactly one cycle per code and deliberately holds chip_en high during the advance and before the first load, so the gating is exercised within those assumptions. The chip values are checked against a model in the bench that steps the two sequences itself. The model reaches the Q position by stepping a copy 131072 positions ahead, not through the fixed taps.

// File: rtl/scramble_gold_gen.sv
module scramble_gold_gen #(
  parameter int CODE_W      = 13,
  parameter int FRAME_CHIPS = 38400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code_num,
  input  logic              chip_en,
  output logic              busy,
  output logic              chip_valid,
  output logic              frame_start,
  output logic [1:0]        chip_i,
  output logic [1:0]        chip_q,
  output logic              is_primary,
  output logic [CODE_W-5:0] set_index,
  output logic [CODE_W-8:0] group_num
);
  localparam int SR_W  = 18;
  localparam int CNT_W = $clog2(FRAME_CHIPS);
  localparam logic [CNT_W-1:0] LAST_CHIP = CNT_W'(FRAME_CHIPS - 1);
  localparam logic [SR_W-1:0]  X_INIT = SR_W'(1);
  localparam logic [SR_W-1:0]  Y_INIT = '1;

  logic [SR_W-1:0]   x_sr, y_sr, x_start;
  logic [CODE_W-1:0] skip_cnt;
  logic [CNT_W-1:0]  chip_cnt;
  logic              running;

  logic [SR_W-1:0] x_nxt, y_nxt;
  logic            i_bit, q_bit;
  logic            ready;

  assign x_nxt = {x_sr[0] ^ x_sr[7], x_sr[SR_W-1:1]};
  assign y_nxt = {y_sr[0] ^ y_sr[5] ^ y_sr[7] ^ y_sr[10], y_sr[SR_W-1:1]};

  assign i_bit = x_sr[0] ^ y_sr[0];
  assign q_bit = (x_sr[4] ^ x_sr[6] ^ x_sr[15]) ^
                 (y_sr[5] ^ y_sr[6] ^ y_sr[8] ^ y_sr[9] ^ y_sr[10] ^
                  y_sr[11] ^ y_sr[12] ^ y_sr[13] ^ y_sr[14] ^ y_sr[15]);

  assign busy  = (skip_cnt != '0);
  assign ready = running && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_sr        <= X_INIT;
      y_sr        <= Y_INIT;
      x_start     <= X_INIT;
      skip_cnt    <= '0;
      chip_cnt    <= '0;
      running     <= 1'b0;
      chip_valid  <= 1'b0;
      frame_start <= 1'b0;
      chip_i      <= 2'b01;
      chip_q      <= 2'b01;
      is_primary  <= 1'b0;
      set_index   <= '0;
      group_num   <= '0;
    end else if (load) begin
      x_sr        <= X_INIT;
      y_sr        <= Y_INIT;
      x_start     <= X_INIT;
      skip_cnt    <= code_num;
      chip_cnt    <= '0;
      running     <= 1'b1;
      chip_valid  <= 1'b0;
      frame_start <= 1'b0;
      is_primary  <= (code_num[3:0] == 4'd0);
      set_index   <= code_num[CODE_W-1:4];
      group_num   <= code_num[CODE_W-1:7];
    end else if (busy) begin
      x_sr        <= x_nxt;
      x_start     <= x_nxt;
      skip_cnt    <= skip_cnt - 1'b1;
      chip_valid  <= 1'b0;
      frame_start <= 1'b0;
    end else if (chip_en && ready) begin
      chip_valid  <= 1'b1;
      frame_start <= (chip_cnt == '0);
      chip_i      <= i_bit ? 2'b11 : 2'b01;
      chip_q      <= q_bit ? 2'b11 : 2'b01;
      if (chip_cnt == LAST_CHIP) begin
        x_sr     <= x_start;
        y_sr     <= Y_INIT;
        chip_cnt <= '0;
      end else begin
        x_sr     <= x_nxt;
        y_sr     <= y_nxt;
        chip_cnt <= chip_cnt + 1'b1;
      end
    end else begin
      chip_valid  <= 1'b0;
      frame_start <= 1'b0;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !busy && !chip_valid && !frame_start) else $error("reset state"); // R1
  AST_INFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(set_index) && $stable(group_num) && $stable(is_primary)) else $error("info changed"); // R2
  AST_ZERO_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n) load && code_num == '0 |=> !busy) else $error("busy on code 0"); // R3
  AST_BUSY_NO_CHIP: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !chip_valid) else $error("chip while busy"); // R4
  AST_IDLE_NO_CHIP: assert property (@(posedge clk) disable iff (!rst_n) !running |=> !chip_valid) else $error("chip before load"); // R4
  AST_CHIP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) chip_valid |-> (chip_i == 2'b01 || chip_i == 2'b11) && (chip_q == 2'b01 || chip_q == 2'b11)) else $error("illegal chip"); // R5
  AST_FRAME_WITH_CHIP: assert property (@(posedge clk) disable iff (!rst_n) frame_start |-> chip_valid) else $error("frame without chip"); // R7
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) chip_cnt <= LAST_CHIP) else $error("chip count range"); // R7
  AST_LOAD_KILLS: assert property (@(posedge clk) disable iff (!rst_n) load |=> !chip_valid) else $error("chip after load"); // R8
  AST_VALID_FROM_EN: assert property (@(posedge clk) disable iff (!rst_n) chip_valid |-> $past(chip_en)) else $error("chip without enable"); // R9
endmodule

// File: tb/scramble_gold_gen_bench.sv
module scramble_gold_gen_bench;
  localparam int FRAME = 38400;
  localparam int NV = 6;
  localparam int V_CODE [NV] = '{0, 16, 37, 1280, 4001, 8191};
  localparam int V_N    [NV] = '{60, 40, 30, 30, 30, 40};
  localparam int V_PRIM [NV] = '{1, 1, 0, 1, 0, 0};
  localparam int V_SET  [NV] = '{0, 1, 2, 80, 250, 511};
  localparam int V_GRP  [NV] = '{0, 0, 0, 10, 31, 63};
  localparam int V_GAP  [NV] = '{0, 1, 0, 1, 0, 1};

  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, chip_en = 1'b0;
  logic [12:0] code_num = '0;
  logic busy, chip_valid, frame_start, is_primary;
  logic [1:0] chip_i, chip_q;
  logic [8:0] set_index;
  logic [5:0] group_num;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  scramble_gold_gen u_scramble_gold_gen (
    .clk(clk), .rst_n(rst_n), .load(load), .code_num(code_num), .chip_en(chip_en),
    .busy(busy), .chip_valid(chip_valid), .frame_start(frame_start),
    .chip_i(chip_i), .chip_q(chip_q), .is_primary(is_primary),
    .set_index(set_index), .group_num(group_num));

  logic [17:0] mx, my, mxq, myq, sx, sxq, syq;
  int midx;

  function automatic logic [17:0] stx(input logic [17:0] s);
    return {s[0] ^ s[7], s[17:1]};
  endfunction
  function automatic logic [17:0] sty(input logic [17:0] s);
    return {s[0] ^ s[5] ^ s[7] ^ s[10], s[17:1]};
  endfunction

  task automatic check(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_init(input int n);
    sx = 18'd1;
    for (int k = 0; k < n; k++) sx = stx(sx);
    sxq = sx;
    syq = '1;
    for (int k = 0; k < 131072; k++) begin
      sxq = stx(sxq);
      syq = sty(syq);
    end
    mx = sx; my = '1; mxq = sxq; myq = syq; midx = 0;
  endtask

  task automatic model_step();
    if (midx == FRAME - 1) begin
      mx = sx; my = '1; mxq = sxq; myq = syq; midx = 0;
    end else begin
      mx = stx(mx); my = sty(my); mxq = stx(mxq); myq = sty(myq); midx++;
    end
  endtask

  task automatic load_code(input int code);
    @(negedge clk);
    load = 1'b1; code_num = 13'(code); chip_en = 1'b1;
    @(negedge clk);
    load = 1'b0;
    model_init(code);
  endtask

  task automatic run_chips(input int n, input int gap, input string tag);
    for (int k = 0; k < n; k++) begin
      logic en;
      en = (gap != 0) ? (k % 3 != 2) : 1'b1;
      chip_en = en;
      @(negedge clk);
      if (en) begin
        logic [1:0] ei, eq;
        ei = (mx[0] ^ my[0]) ? 2'b11 : 2'b01;
        eq = (mxq[0] ^ myq[0]) ? 2'b11 : 2'b01;
        check({tag, " R9 valid"}, chip_valid === 1'b1, chip_valid, 1);
        check("R5 chip_i", chip_i === ei, chip_i, ei);
        check("R6 chip_q", chip_q === eq, chip_q, eq);
        check("R7 frame_start", frame_start === (midx == 0), frame_start, midx == 0);
        model_step();
      end else begin
        check("R9 gap no valid", chip_valid === 1'b0, chip_valid, 0);
      end
    end
    chip_en = 1'b0;
  endtask

  task automatic do_vector(input int v);
    int bc;
    load_code(V_CODE[v]);
    check("R2 is_primary", is_primary === V_PRIM[v][0], is_primary, V_PRIM[v]);
    check("R2 set_index", int'(set_index) == V_SET[v], set_index, V_SET[v]);
    check("R2 group_num", int'(group_num) == V_GRP[v], group_num, V_GRP[v]);
    bc = 0;
    while (busy === 1'b1 && bc < 9000) begin
      check("R4 no chip while busy", chip_valid === 1'b0, chip_valid, 0);
      bc++;
      @(negedge clk);
    end
    check("R3 busy length", bc == V_CODE[v], bc, V_CODE[v]);
    run_chips(V_N[v], V_GAP[v], "vector");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", busy === 1'b0, busy, 0);
    check("R1 chip_valid", chip_valid === 1'b0, chip_valid, 0);
    check("R1 frame_start", frame_start === 1'b0, frame_start, 0);
    rst_n = 1'b1;
    chip_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R4 no chip before load", chip_valid === 1'b0, chip_valid, 0);
    end
    chip_en = 1'b0;

    for (int v = 0; v < NV; v++) do_vector(v);

    // R8: reload in the middle of a running stream
    load_code(37);
    repeat (37) @(negedge clk);
    run_chips(12, 0, "R8 first");
    load_code(16);
    check("R8 no chip after reload", chip_valid === 1'b0, chip_valid, 0);
    check("R8 busy restarts", busy === 1'b1, busy, 1);
    repeat (16) @(negedge clk);
    run_chips(20, 0, "R8 second");

    // R7: full frame wrap
    load_code(5);
    repeat (5) @(negedge clk);
    run_chips(FRAME + 6, 0, "R7 wrap");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule